// File: doc/BRIEF.md
# Monitor Channel Handshake Engine

This block carries register traffic over the monitor byte of a framed serial highway. A new frame arrives every 125 µs. Each frame holds one monitor byte and one signalling byte. The signalling byte has six command/indicate (C/I) bits and two active-low handshake bits. The transmit-strobe bit tells the receiver that a monitor byte is valid. The receive-acknowledge bit confirms that a byte was taken. Bit-level serialisation of the highway is done outside this block. It sees each frame as a single-cycle strobe with the downstream fields beside it, and it returns registered upstream fields that hold for the whole next frame.

**Downstream messages.** The host sends messages downstream one byte at a time.
- A byte counts as received only when it has been seen twice with the strobe bit active: a first look, then a matching last look.
- The block then acknowledges the byte and waits for the host to release its strobe.
- A write message is a command byte, an address byte and one data byte per register. Each data byte becomes a one-cycle write toward the core.
- A read message is a command byte and an address byte. When the message closes, the block fetches a fixed number of registers from the core. It sends them upstream with the same per-byte acknowledge protocol. If the highway shows a strobe value different from the one the block drove, the block stops sending.

**C/I path.** The C/I bits go to the core only after two frames that agree. Core C/I bits are copied upstream once per frame.

Top module: `mon_hs_top`

## Requirements
- R1: After reset the upstream monitor byte is 0xFF, both upstream handshake bits are 1, the upstream and core-side C/I values are all ones, and no register write or read is issued.
- R2: While nothing is being sent upstream, the upstream monitor byte is 0xFF and the upstream strobe bit is 1. Upstream outputs change only in the cycle after a frame strobe.
- R3: A downstream byte is accepted only when two consecutive frames carry the strobe bit at 0 and the same monitor byte. The acknowledge bit goes to 0 right after the second of those frames. It returns to 1 after the first frame in which the host strobe is back at 1.
- R4: The block aborts the current message in either of two cases:
  - the two looks at a byte differ;
  - the strobe returns to 1 before the last look.

  An aborted byte is never acknowledged or written. All later bytes are ignored until two consecutive frames arrive with the strobe at 1. After that, a new message is received normally.
- R5: A message starting with command 0xA0 writes each data byte after the address byte. The first data byte goes to that address and each later one to the next address. Each write is a one-cycle pulse in the cycle after the accepting frame.
- R6: A message ends after an acknowledged byte when the strobe stays at 1 for two consecutive frames. A read response never starts before the second of those frames.
- R7: A message of command 0xA1 and an address byte is answered with RD_LEN bytes, read from consecutive addresses that wrap at the address width. Each byte goes out with the upstream strobe at 0 and is held until the host acknowledge reads 0. The strobe then goes to 1 for at least one frame before the next byte.
- R8: While a byte is being sent, a frame whose sampled upstream strobe differs from the driven value is a collision. On a collision the block drives the strobe to 1 and the monitor byte to 0xFF, and it sends no further bytes of that response.
- R9: The core-side C/I value and its one-cycle change pulse update only when two consecutive frames carry the same new C/I code. A single-frame code has no effect.
- R10: The upstream C/I field takes the core C/I input at each frame strobe and holds it between strobes.
- R11: Messages with any other command byte are still acknowledged byte by byte, but they cause no write and no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_vld | input | 1 | One-cycle strobe marking a received frame |
| dn_mon | input | 8 | Downstream monitor byte |
| dn_mx | input | 1 | Downstream transmit strobe, active low |
| dn_mr | input | 1 | Downstream acknowledge, active low |
| dn_ci | input | CI_W | Downstream C/I code |
| up_mx_smp | input | 1 | Upstream strobe as seen on the highway in the frame just ended |
| up_mon | output | 8 | Upstream monitor byte |
| up_mx | output | 1 | Upstream transmit strobe, active low |
| up_mr | output | 1 | Upstream acknowledge, active low |
| up_ci | output | CI_W | Upstream C/I code |
| core_ci_in | input | CI_W | C/I code supplied by the core |
| core_ci_out | output | CI_W | Filtered downstream C/I code |
| core_ci_chg | output | 1 | One-cycle pulse when core_ci_out changes |
| reg_we | output | 1 | Register write pulse |
| reg_re | output | 1 | Register read request, data due one cycle later |
| reg_addr | output | AW | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data |

## Verification
The bench targets several corner cases:
- A last look that differs from the first look. A receiver that skipped the second sample would acknowledge and write a corrupted byte.
- A strobe released one frame early. A block that treated one idle frame as the end of a message would start a read response too soon.
- A read that starts at the top address. Broken address arithmetic would return the wrong byte after the wrap.
- A collision injected on the first response byte. A transmitter that only looked at the acknowledge would keep sending.
- A C/I code that lasts only one frame. An unfiltered path would pass that glitch to the core.

// File: rtl/mon_hs_pkg.sv
package mon_hs_pkg;
  localparam logic [7:0] IDLE_BYTE = 8'hFF;

  typedef enum logic [2:0] {
    RX_IDLE, RX_LOOK, RX_ACK, RX_GAP, RX_DROP
  } rx_st_e;

  typedef enum logic [2:0] {
    TX_IDLE, TX_FETCH, TX_WAIT, TX_LATCH, TX_ARM, TX_SEND
  } tx_st_e;
endpackage

// File: rtl/mon_rx.sv
module mon_rx
  import mon_hs_pkg::*;
#(
  parameter int          AW     = 8,
  parameter logic [7:0]  CMD_WR = 8'hA0,
  parameter logic [7:0]  CMD_RD = 8'hA1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frm_vld,
  input  logic          dn_mx,
  input  logic [7:0]    dn_mon,
  input  logic          tx_busy,
  output logic          up_mr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          rd_start,
  output logic [AW-1:0] rd_base
);
  rx_st_e        st;
  logic [7:0]    cap;
  logic [7:0]    cmd;
  logic [1:0]    idx;
  logic [AW-1:0] ofs;
  logic          quiet;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= RX_IDLE; cap <= '0; cmd <= '0; idx <= '0; ofs <= '0; quiet <= 1'b0;
      up_mr <= 1'b1; wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
      rd_start <= 1'b0; rd_base <= '0;
    end else begin
      wr_en    <= 1'b0;
      rd_start <= 1'b0;
      if (frm_vld) begin
        case (st)
          RX_IDLE: if (!dn_mx && !tx_busy) begin
            cap <= dn_mon; st <= RX_LOOK;
          end
          RX_LOOK: begin
            if (dn_mx) begin
              st <= RX_DROP; quiet <= 1'b1;
            end else if (dn_mon != cap) begin
              st <= RX_DROP; quiet <= 1'b0;
            end else begin
              up_mr <= 1'b0;
              st    <= RX_ACK;
              case (idx)
                2'd0: begin cmd <= cap; idx <= 2'd1; end
                2'd1: begin rd_base <= cap[AW-1:0]; ofs <= '0; idx <= 2'd2; end
                default: if (cmd == CMD_WR) begin
                  wr_en   <= 1'b1;
                  wr_addr <= rd_base + ofs;
                  wr_data <= cap;
                  ofs     <= ofs + 1'b1;
                end
              endcase
            end
          end
          RX_ACK: if (dn_mx) begin
            up_mr <= 1'b1; st <= RX_GAP;
          end
          RX_GAP: begin
            if (!dn_mx) begin
              cap <= dn_mon; st <= RX_LOOK;
            end else begin
              st  <= RX_IDLE;
              idx <= '0;
              if (cmd == CMD_RD && idx == 2'd2) rd_start <= 1'b1;
            end
          end
          RX_DROP: begin
            if (dn_mx) begin
              if (quiet) begin st <= RX_IDLE; idx <= '0; end
              quiet <= 1'b1;
            end else begin
              quiet <= 1'b0;
            end
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  p_ack_look_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(up_mr) |-> ($past(frm_vld) && $past(st) == RX_LOOK && $past(dn_mon) == $past(cap) && !$past(dn_mx)));

  p_wr_frame_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($past(frm_vld) && $past(cmd) == CMD_WR && $past(idx) == 2'd2));

  p_end_two_idle_r6: assert property (@(posedge clk) disable iff (rst)
    rd_start |-> ($past(frm_vld) && $past(st) == RX_GAP && $past(dn_mx)));
endmodule

// File: rtl/mon_tx.sv
module mon_tx
  import mon_hs_pkg::*;
#(
  parameter int AW     = 8,
  parameter int RD_LEN = 2,
  localparam int LW    = $clog2(RD_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frm_vld,
  input  logic          dn_mr,
  input  logic          up_mx_smp,
  input  logic          rd_start,
  input  logic [AW-1:0] rd_base,
  input  logic [7:0]    rd_data,
  output logic          up_mx,
  output logic [7:0]    up_mon,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          busy
);
  tx_st_e     st;
  logic [LW-1:0] left;
  logic [7:0] byte_q;

  assign busy = (st != TX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= TX_IDLE; left <= '0; byte_q <= '0;
      up_mx <= 1'b1; up_mon <= IDLE_BYTE; rd_en <= 1'b0; rd_addr <= '0;
    end else begin
      rd_en <= 1'b0;
      case (st)
        TX_IDLE: if (rd_start) begin
          rd_addr <= rd_base; left <= LW'(RD_LEN); st <= TX_FETCH;
        end
        TX_FETCH: begin rd_en <= 1'b1; st <= TX_WAIT; end
        TX_WAIT:  st <= TX_LATCH;
        TX_LATCH: begin byte_q <= rd_data; st <= TX_ARM; end
        TX_ARM: if (frm_vld) begin
          up_mx <= 1'b0; up_mon <= byte_q; st <= TX_SEND;
        end
        TX_SEND: if (frm_vld) begin
          if (up_mx_smp != up_mx) begin
            up_mx <= 1'b1; up_mon <= IDLE_BYTE; left <= '0; st <= TX_IDLE;
          end else if (!dn_mr) begin
            up_mx   <= 1'b1;
            up_mon  <= IDLE_BYTE;
            rd_addr <= rd_addr + 1'b1;
            left    <= left - 1'b1;
            st      <= (left == LW'(1)) ? TX_IDLE : TX_FETCH;
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  p_collision_abort_r8: assert property (@(posedge clk) disable iff (rst)
    (frm_vld && st == TX_SEND && up_mx_smp != up_mx) |=> (up_mx && st == TX_IDLE));

  p_idle_byte_r2: assert property (@(posedge clk) disable iff (rst)
    up_mx |-> (up_mon == IDLE_BYTE));

  p_strobe_on_frame_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(up_mx) |-> ($past(frm_vld) && $past(st) == TX_ARM));
endmodule

// File: rtl/ci_filt.sv
module ci_filt #(
  parameter int CI_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frm_vld,
  input  logic [CI_W-1:0] dn_ci,
  input  logic [CI_W-1:0] core_ci_in,
  output logic [CI_W-1:0] core_ci_out,
  output logic            core_ci_chg,
  output logic [CI_W-1:0] up_ci
);
  logic [CI_W-1:0] last_ci;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_ci <= '1; core_ci_out <= '1; core_ci_chg <= 1'b0; up_ci <= '1;
    end else begin
      core_ci_chg <= 1'b0;
      if (frm_vld) begin
        last_ci <= dn_ci;
        up_ci   <= core_ci_in;
        if (dn_ci == last_ci && dn_ci != core_ci_out) begin
          core_ci_out <= dn_ci;
          core_ci_chg <= 1'b1;
        end
      end
    end
  end

  p_ci_two_frames_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(core_ci_out) |-> ($past(frm_vld) && core_ci_chg && core_ci_out == $past(dn_ci) && $past(last_ci) == $past(dn_ci)));

  p_upci_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(frm_vld) |-> $stable(up_ci));
endmodule

// File: rtl/mon_hs_top.sv
module mon_hs_top
  import mon_hs_pkg::*;
#(
  parameter int         AW     = 8,
  parameter int         CI_W   = 6,
  parameter int         RD_LEN = 2,
  parameter logic [7:0] CMD_WR = 8'hA0,
  parameter logic [7:0] CMD_RD = 8'hA1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frm_vld,
  input  logic [7:0]      dn_mon,
  input  logic            dn_mx,
  input  logic            dn_mr,
  input  logic [CI_W-1:0] dn_ci,
  input  logic            up_mx_smp,
  output logic [7:0]      up_mon,
  output logic            up_mx,
  output logic            up_mr,
  output logic [CI_W-1:0] up_ci,
  input  logic [CI_W-1:0] core_ci_in,
  output logic [CI_W-1:0] core_ci_out,
  output logic            core_ci_chg,
  output logic            reg_we,
  output logic            reg_re,
  output logic [AW-1:0]   reg_addr,
  output logic [7:0]      reg_wdata,
  input  logic [7:0]      reg_rdata
);
  logic          tx_busy;
  logic          rd_start;
  logic [AW-1:0] rd_base;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;

  mon_rx #(.AW(AW), .CMD_WR(CMD_WR), .CMD_RD(CMD_RD)) u_rx (
    .clk(clk), .rst(rst), .frm_vld(frm_vld), .dn_mx(dn_mx), .dn_mon(dn_mon),
    .tx_busy(tx_busy), .up_mr(up_mr), .wr_en(reg_we), .wr_addr(wr_addr),
    .wr_data(reg_wdata), .rd_start(rd_start), .rd_base(rd_base)
  );

  mon_tx #(.AW(AW), .RD_LEN(RD_LEN)) u_tx (
    .clk(clk), .rst(rst), .frm_vld(frm_vld), .dn_mr(dn_mr), .up_mx_smp(up_mx_smp),
    .rd_start(rd_start), .rd_base(rd_base), .rd_data(reg_rdata),
    .up_mx(up_mx), .up_mon(up_mon), .rd_en(reg_re), .rd_addr(rd_addr), .busy(tx_busy)
  );

  ci_filt #(.CI_W(CI_W)) u_ci (
    .clk(clk), .rst(rst), .frm_vld(frm_vld), .dn_ci(dn_ci), .core_ci_in(core_ci_in),
    .core_ci_out(core_ci_out), .core_ci_chg(core_ci_chg), .up_ci(up_ci)
  );

  assign reg_addr = reg_we ? wr_addr : rd_addr;

  p_no_rw_clash_r7: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_re));

  p_tx_after_rx_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(up_mx) |-> up_mr);
endmodule

// File: tb/mon_hs_top_tb.sv
module mon_hs_top_tb;
  localparam int FP = 8;
  localparam int RD_LEN = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frm_vld = 1'b0;
  logic [7:0] dn_mon = 8'hFF;
  logic dn_mx = 1'b1, dn_mr = 1'b1, up_mx_smp = 1'b1;
  logic [5:0] dn_ci = 6'h3F, core_ci_in = 6'h3F;
  logic [7:0] up_mon, reg_wdata, reg_rdata;
  logic up_mx, up_mr, core_ci_chg, reg_we, reg_re;
  logic [5:0] up_ci, core_ci_out;
  logic [7:0] reg_addr;

  int total = 0, bad = 0, chg_n = 0;
  logic [5:0] cur_ci = 6'h3F;
  bit flip_smp = 0;
  logic [7:0] mem [256];
  logic [7:0] exp_wa [$];
  logic [7:0] exp_wd [$];
  logic [7:0] got [$];
  logic vld_pos = 0;
  logic [7:0] pm; logic px, pr;

  always #4 clk = ~clk;

  mon_hs_top #(.RD_LEN(RD_LEN)) u_dut (
    .clk(clk), .rst(rst), .frm_vld(frm_vld), .dn_mon(dn_mon), .dn_mx(dn_mx),
    .dn_mr(dn_mr), .dn_ci(dn_ci), .up_mx_smp(up_mx_smp), .up_mon(up_mon),
    .up_mx(up_mx), .up_mr(up_mr), .up_ci(up_ci), .core_ci_in(core_ci_in),
    .core_ci_out(core_ci_out), .core_ci_chg(core_ci_chg), .reg_we(reg_we),
    .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // register file model with one-cycle read latency
  always @(posedge clk) begin
    vld_pos <= frm_vld;
    if (reg_re) reg_rdata <= mem[reg_addr];
    if (reg_we) mem[reg_addr] <= reg_wdata;
  end

  // per-clock checks: writes against expectation, upstream stability
  always @(negedge clk) begin
    if (!rst) begin
      if (reg_we) begin
        if (exp_wa.size() == 0) chk(0, "R4/R11 unexpected write", reg_addr, 0);
        else begin
          chk(reg_addr == exp_wa[0], "R5 addr", reg_addr, exp_wa[0]);
          chk(reg_wdata == exp_wd[0], "R5 data", reg_wdata, exp_wd[0]);
          void'(exp_wa.pop_front()); void'(exp_wd.pop_front());
        end
      end
      if (core_ci_chg) chg_n++;
      if (!vld_pos)
        chk(up_mon == pm && up_mx == px && up_mr == pr, "R2 stable", {up_mon, up_mx, up_mr}, {pm, px, pr});
    end
    pm = up_mon; px = up_mx; pr = up_mr;
  end

  task automatic frame(input logic mx, input logic mr, input logic [7:0] mon);
    @(negedge clk);
    dn_mx = mx; dn_mr = mr; dn_mon = mon; dn_ci = cur_ci;
    up_mx_smp = up_mx ^ flip_smp; frm_vld = 1'b1;
    @(negedge clk);
    frm_vld = 1'b0; flip_smp = 0;
    repeat (FP - 2) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    int n = 0; bit ack = 0;
    for (int i = 0; i < 8 && !ack; i++) begin
      frame(1'b0, 1'b1, b); n++;
      if (!up_mr) ack = 1;
    end
    chk(ack && n == 2, "R3 ack after last look", n, 2);
    frame(1'b1, 1'b1, 8'hFF);
    chk(up_mr == 1'b1, "R3 ack release", up_mr, 1);
  endtask

  task automatic end_msg();
    frame(1'b1, 1'b1, 8'hFF);
  endtask

  task automatic recv(input int frames, input bit coll);
    bit inb = 0;
    got.delete();
    for (int i = 0; i < frames; i++) begin
      if (!up_mx && !inb) got.push_back(up_mon);
      if (coll && !up_mx) begin
        flip_smp = 1;
        inb = 1;
        frame(1'b1, 1'b1, 8'hFF);
        chk(up_mx == 1'b1 && up_mon == 8'hFF, "R8 collision abort", {up_mx, up_mon}, 9'h1FF);
        coll = 0;
      end else begin
        inb = !up_mx;
        frame(1'b1, up_mx, 8'hFF);
      end
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 5);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(up_mon == 8'hFF, "R1 up_mon", up_mon, 8'hFF);
    chk(up_mx == 1'b1 && up_mr == 1'b1, "R1 handshake", {up_mx, up_mr}, 2'b11);
    chk(up_ci == 6'h3F && core_ci_out == 6'h3F, "R1 ci", {up_ci, core_ci_out}, 12'hFFF);
    chk(!reg_we && !reg_re, "R1 reg idle", {reg_we, reg_re}, 0);

    // R2 idle frames
    repeat (3) frame(1'b1, 1'b1, 8'hFF);
    chk(up_mon == 8'hFF && up_mx && up_mr, "R2 idle", {up_mon, up_mx, up_mr}, 10'h3FF);

    // R5 write message
    exp_wa = '{8'h10, 8'h11, 8'h12}; exp_wd = '{8'h11, 8'h22, 8'h33};
    send_byte(8'hA0); send_byte(8'h10);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
    end_msg(); frame(1'b1, 1'b1, 8'hFF);
    chk(exp_wa.size() == 0, "R5 all writes", exp_wa.size(), 0);

    // R7 / R6 read message
    send_byte(8'hA1); send_byte(8'h10);
    chk(up_mx == 1'b1, "R6 no response before end", up_mx, 1);
    end_msg();
    recv(20, 0);
    chk(got.size() == RD_LEN, "R7 count", got.size(), RD_LEN);
    if (got.size() == RD_LEN) begin
      chk(got[0] == 8'h11, "R7 byte0", got[0], 8'h11);
      chk(got[1] == 8'h22, "R7 byte1", got[1], 8'h22);
    end

    // R7 address wrap
    send_byte(8'hA1); send_byte(8'hFF); end_msg();
    recv(20, 0);
    chk(got.size() == RD_LEN, "R7 wrap count", got.size(), RD_LEN);
    if (got.size() == RD_LEN) begin
      chk(got[0] == mem[255], "R7 wrap byte0", got[0], mem[255]);
      chk(got[1] == mem[0], "R7 wrap byte1", got[1], mem[0]);
    end

    // R4 last-look mismatch on command byte
    frame(1'b0, 1'b1, 8'hA0); frame(1'b0, 1'b1, 8'hA5);
    chk(up_mr == 1'b1, "R4 no ack on mismatch", up_mr, 1);
    repeat (3) frame(1'b0, 1'b1, 8'hA5);
    chk(up_mr == 1'b1, "R4 ignored until idle", up_mr, 1);
    frame(1'b1, 1'b1, 8'hFF); frame(1'b1, 1'b1, 8'hFF);
    exp_wa = '{8'h20}; exp_wd = '{8'h5A};
    send_byte(8'hA0); send_byte(8'h20); send_byte(8'h5A); end_msg();
    frame(1'b1, 1'b1, 8'hFF);
    chk(exp_wa.size() == 0, "R4 recovery write", exp_wa.size(), 0);

    // R4 mismatch on data byte: no write
    send_byte(8'hA0); send_byte(8'h30);
    frame(1'b0, 1'b1, 8'h77); frame(1'b0, 1'b1, 8'h78);
    chk(up_mr == 1'b1, "R4 data mismatch no ack", up_mr, 1);
    frame(1'b1, 1'b1, 8'hFF); frame(1'b1, 1'b1, 8'hFF); frame(1'b1, 1'b1, 8'hFF);
    chk(mem[8'h30] == 8'(8'h30 * 37 + 5), "R4 no write", mem[8'h30], 8'(8'h30 * 37 + 5));

    // R11 unknown command
    send_byte(8'h33); send_byte(8'h40); send_byte(8'h55); end_msg();
    recv(10, 0);
    chk(got.size() == 0, "R11 no response", got.size(), 0);

    // R8 collision on first response byte
    send_byte(8'hA1); send_byte(8'h10); end_msg();
    recv(20, 1);
    chk(got.size() == 1, "R8 stops after collision", got.size(), 1);
    if (got.size() > 0) chk(got[0] == 8'h11, "R8 first byte", got[0], 8'h11);

    // R9 C/I filtering
    cur_ci = 6'h05; frame(1'b1, 1'b1, 8'hFF);
    cur_ci = 6'h3F; frame(1'b1, 1'b1, 8'hFF);
    chk(core_ci_out == 6'h3F && chg_n == 0, "R9 glitch ignored", {core_ci_out, 8'(chg_n)}, 6'h3F);
    cur_ci = 6'h05; frame(1'b1, 1'b1, 8'hFF);
    chk(core_ci_out == 6'h3F, "R9 one frame only", core_ci_out, 6'h3F);
    frame(1'b1, 1'b1, 8'hFF);
    chk(core_ci_out == 6'h05 && chg_n == 1, "R9 two frames", {core_ci_out, 8'(chg_n)}, {6'h05, 8'd1});

    // R10 upstream C/I
    @(negedge clk); core_ci_in = 6'h2A;
    repeat (2) @(negedge clk);
    chk(up_ci == 6'h3F, "R10 hold between frames", up_ci, 6'h3F);
    frame(1'b1, 1'b1, 8'hFF);
    chk(up_ci == 6'h2A, "R10 update at frame", up_ci, 6'h2A);

    summary();
    $finish;
  end
endmodule